// File: doc/BRIEF.md
# Programmable Interval Pulse Timer

This block produces a periodic or single-shot interval event from a 32.768 kHz oscillator clock. When each selected interval ends, it pulls an active-low, open-drain style output low for exactly one oscillator cycle, which is about 30.5 µs. It also sets a sticky interval flag that the host can poll. The interval is chosen from five lengths: 0.1 s, 1 s, 10 s, 30 s and 60 s. A reserved code hands the output pin to an external busy indication instead of the interval events.

Counting can be paused and resumed without losing the time already elapsed. A separate clear input drops the partial interval, the flag and the single-shot halt. An enable input parks the pin high. In the 0.1 s setting each half second is split into five periods whose lengths differ by at most one cycle. Five consecutive periods therefore add up to exactly one half second. At the default rate the five lengths are 3277, 3277, 3276, 3277 and 3277 cycles.

Top module: `ivt_interval_timer`

## Requirements
- R1: While reset is asserted, and after it is released with `run` low, `pulse_n` is 1 and `interval_flag` is 0.
- R2: `period_sel` picks the interval in repeat mode. Code 000 is 0.1 s. Code 001 is 2 half seconds, 010 is 20, 011 is 60 and 100 is 120, where one half second is `HALF_SEC_CYC` cycles. Successive pulses are spaced by exactly that many cycles.
- R3: In code 000 the five periods of each half second last B+1, B+1, B, B+1 and B cycles in slot order when HALF_SEC_CYC mod 5 = 3, and B+1, B+1, B, B+1, B+1 when it is 4, with B = HALF_SEC_CYC/5. Their sum is always HALF_SEC_CYC.
- R4: An interval event drives `pulse_n` low for exactly one cycle. Counting from the first counting edge, the pin is low just after edge number P, where P is the interval length.
- R5: With `one_shot` = 0 the timer keeps producing pulses without host action.
- R6: With `one_shot` = 1 exactly one pulse is produced after each start. Counting then halts until `cnt_reset`.
- R7: While `run` = 0 the count is frozen. After `run` returns to 1, the next pulse comes after the remaining cycles only, so t1 + t2 = P.
- R8: A cycle with `cnt_reset` = 1 discards the elapsed time, clears the flag and clears the single-shot halt. The next pulse then comes P counting edges after release.
- R9: `interval_flag` goes to 1 on the edge that lowers the pin for an event. It stays 1 until `cnt_reset`.
- R10: With `out_en` = 0, `pulse_n` is 1 one cycle later, and events still set the flag.
- R11: With code 111, `pulse_n` equals the inverse of `busy_in` one cycle later (if `out_en` = 1). No interval events are produced.
- R12: Codes 101 and 110 produce no events: the pin stays 1 and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 3 | Interval code (see R2, R11, R12) |
| one_shot | input | 1 | 1 = single shot, 0 = repeat |
| run | input | 1 | 1 = count, 0 = freeze |
| cnt_reset | input | 1 | Synchronous clear of count, flag and halt |
| out_en | input | 1 | 1 = pin may go low, 0 = pin held high |
| busy_in | input | 1 | Busy indication routed to the pin with code 111 |
| pulse_n | output | 1 | Active-low event pin, registered |
| interval_flag | output | 1 | Sticky event flag |

## Verification
Several properties are checked on every clock. The divider stays inside its slot and cycle ranges and does not move while stopped. An event never fires twice in a row or while a single shot is halted. The flag does not drop without a clear. The pin stays high after a disable. Only the bench scenarios can show the actual spacing between pulses for each code, the uneven five-period split of the 0.1 s setting, the t1 + t2 = P behaviour across a stop, and the restart after a clear.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    SPAN_TENTH = 3'b000,
    SPAN_1S    = 3'b001,
    SPAN_10S   = 3'b010,
    SPAN_30S   = 3'b011,
    SPAN_60S   = 3'b100,
    SPAN_RSV5  = 3'b101,
    SPAN_RSV6  = 3'b110,
    SPAN_BUSY  = 3'b111
  } span_e;

  // interval lengths expressed in half seconds
  localparam int unsigned HALVES_1S  = 2;
  localparam int unsigned HALVES_10S = 20;
  localparam int unsigned HALVES_30S = 60;
  localparam int unsigned HALVES_60S = 120;
  localparam int unsigned HALVES_MAX = HALVES_60S;

  // order in which the five tenth slots receive the spare cycles
  function automatic int unsigned slot_rank(input int unsigned slot);
    case (slot)
      0:       slot_rank = 0;
      1:       slot_rank = 1;
      2:       slot_rank = 4;
      3:       slot_rank = 2;
      default: slot_rank = 3;
    endcase
  endfunction

endpackage

// File: rtl/ivt_fifth_div.sv
module ivt_fifth_div
  import ivt_pkg::*;
#(
  parameter int unsigned HALF_SEC_CYC = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic fifth_tick,
  output logic half_tick
);

  localparam int unsigned BASE = HALF_SEC_CYC / 5;
  localparam int unsigned REM  = HALF_SEC_CYC % 5;
  localparam int unsigned CW   = $clog2(BASE + 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [2:0]    slot_q, slot_d;
  logic [7:0]    slot_long;
  logic [CW-1:0] last_cyc;
  logic          wrap;

  // which slots get BASE+1 cycles
  for (genvar gi = 0; gi < 8; gi++) begin : g_slot
    if (gi < 5 && slot_rank(gi) < REM) begin : g_long
      assign slot_long[gi] = 1'b1;
    end else begin : g_short
      assign slot_long[gi] = 1'b0;
    end
  end

  assign last_cyc   = slot_long[slot_q] ? CW'(BASE) : CW'(BASE - 1);
  assign wrap       = en && (cyc_q == last_cyc);
  assign fifth_tick = wrap;
  assign half_tick  = wrap && (slot_q == 3'd4);

  always_comb begin
    cyc_d  = cyc_q;
    slot_d = slot_q;
    if (clr) begin
      cyc_d  = '0;
      slot_d = '0;
    end else if (wrap) begin
      cyc_d  = '0;
      slot_d = (slot_q == 3'd4) ? 3'd0 : slot_q + 3'd1;
    end else if (en) begin
      cyc_d  = cyc_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CW'(BASE)); // R3
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= 3'd4); // R3
  AST_HALF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (slot_q == 3'd0)); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(cyc_q) && $stable(slot_q))); // R7

endmodule

// File: rtl/ivt_span_cnt.sv
module ivt_span_cnt
  import ivt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  span_e sel,
  input  logic  fifth_tick,
  input  logic  half_tick,
  output logic  evt
);

  localparam int unsigned HW = $clog2(HALVES_MAX);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [HW-1:0] target_m1;
  logic          half_mode;

  always_comb begin
    half_mode = 1'b1;
    target_m1 = HW'(HALVES_1S - 1);
    case (sel)
      SPAN_1S:  target_m1 = HW'(HALVES_1S - 1);
      SPAN_10S: target_m1 = HW'(HALVES_10S - 1);
      SPAN_30S: target_m1 = HW'(HALVES_30S - 1);
      SPAN_60S: target_m1 = HW'(HALVES_60S - 1);
      default:  half_mode = 1'b0;
    endcase
  end

  always_comb begin
    hcnt_d = hcnt_q;
    evt    = 1'b0;
    if (clr) begin
      hcnt_d = '0;
    end else if (sel == SPAN_TENTH) begin
      evt = fifth_tick;
    end else if (half_mode && half_tick) begin
      if (hcnt_q >= target_m1) begin
        hcnt_d = '0;
        evt    = 1'b1;
      end else begin
        hcnt_d = hcnt_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
    end
  end

  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q < HW'(HALVES_MAX)); // R2
  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R4

endmodule

// File: rtl/ivt_pin_ctl.sv
module ivt_pin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic one_shot,
  input  logic out_en,
  input  logic busy_mode,
  input  logic busy_in,
  output logic pin_n,
  output logic flag,
  output logic done
);

  logic pin_n_q, pin_n_d;
  logic flag_q,  flag_d;
  logic done_q,  done_d;

  always_comb begin
    if (!out_en) begin
      pin_n_d = 1'b1;
    end else if (busy_mode) begin
      pin_n_d = ~busy_in;
    end else begin
      pin_n_d = ~evt;
    end
  end

  always_comb begin
    flag_d = flag_q;
    done_d = done_q;
    if (clr) begin
      flag_d = 1'b0;
      done_d = 1'b0;
    end else if (evt) begin
      flag_d = 1'b1;
      done_d = one_shot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n_q <= 1'b1;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      pin_n_q <= pin_n_d;
      flag_q  <= flag_d;
      done_q  <= done_d;
    end
  end

  assign pin_n = pin_n_q;
  assign flag  = flag_q;
  assign done  = done_q;

  AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> pin_n_q); // R10
  AST_EVT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && out_en && !busy_mode) |=> (!pin_n_q && flag_q)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R9
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |-> !evt); // R6

endmodule

// File: rtl/ivt_interval_timer.sv
module ivt_interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned HALF_SEC_CYC = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] period_sel,
  input  logic       one_shot,
  input  logic       run,
  input  logic       cnt_reset,
  input  logic       out_en,
  input  logic       busy_in,
  output logic       pulse_n,
  output logic       interval_flag
);

  logic [1:0] rs_q;
  logic       core_rst_n;
  span_e      sel_e;
  logic       timed_sel;
  logic       busy_mode;
  logic       count_en;
  logic       done;
  logic       fifth_tick, half_tick, evt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign core_rst_n = rs_q[1];

  assign sel_e     = span_e'(period_sel);
  assign timed_sel = (period_sel <= 3'b100);
  assign busy_mode = (sel_e == SPAN_BUSY);
  assign count_en  = run && timed_sel && !done && !cnt_reset;

  ivt_fifth_div #(
    .HALF_SEC_CYC(HALF_SEC_CYC)
  ) u_div (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .en         (count_en),
    .clr        (cnt_reset),
    .fifth_tick (fifth_tick),
    .half_tick  (half_tick)
  );

  ivt_span_cnt u_span (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .clr        (cnt_reset),
    .sel        (sel_e),
    .fifth_tick (fifth_tick),
    .half_tick  (half_tick),
    .evt        (evt)
  );

  ivt_pin_ctl u_pin (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clr       (cnt_reset),
    .evt       (evt),
    .one_shot  (one_shot),
    .out_en    (out_en),
    .busy_mode (busy_mode),
    .busy_in   (busy_in),
    .pin_n     (pulse_n),
    .flag      (interval_flag),
    .done      (done)
  );

  AST_NO_EVT_UNTIMED: assert property (@(posedge clk) disable iff (!core_rst_n)
    !timed_sel |-> !evt); // R12
  AST_STOP_NO_EVT: assert property (@(posedge clk) disable iff (!core_rst_n)
    !run |-> !evt); // R7

endmodule

// File: tb/ivt_interval_timer_test.sv
`timescale 1ns/1ps
module ivt_interval_timer_test;

  localparam int H  = 23;
  localparam int NV = 5;
  localparam logic [2:0] VSEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
  localparam int VFIRST [NV] = '{5, 2*H, 20*H, 60*H, 120*H};
  localparam int VNEXT  [NV] = '{5, 2*H, 20*H, 60*H, 120*H};
  localparam int SPLIT  [5]  = '{5, 5, 4, 5, 4};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] period_sel;
  logic       one_shot, run, cnt_reset, out_en, busy_in;
  logic       pulse_n, interval_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ivt_interval_timer #(.HALF_SEC_CYC(H)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_sel    (period_sel),
    .one_shot      (one_shot),
    .run           (run),
    .cnt_reset     (cnt_reset),
    .out_en        (out_en),
    .busy_in       (busy_in),
    .pulse_n       (pulse_n),
    .interval_flag (interval_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts negedges until pulse_n is seen low; -1 if none within lim
  task automatic wait_low(input int lim, output int cnt);
    cnt = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (!pulse_n) begin
        cnt = i;
        break;
      end
    end
  endtask

  // counts low samples over n cycles
  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!pulse_n) lows++;
    end
  endtask

  task automatic clear_count();
    cnt_reset = 1'b1;
    tick(1);
    cnt_reset = 1'b0;
  endtask

  initial begin
    int g, lows, sum;
    rst_n = 1'b0; period_sel = 3'd0; one_shot = 1'b0; run = 1'b0;
    cnt_reset = 1'b0; out_en = 1'b1; busy_in = 1'b0;
    tick(3);
    check("R1 pin in reset", int'(pulse_n), 1);
    check("R1 flag in reset", int'(interval_flag), 0);
    rst_n = 1'b1;
    tick(4);
    count_lows(20, lows);
    check("R1 idle after reset lows", lows, 0);
    check("R1 idle flag", int'(interval_flag), 0);

    // vector table: code, first spacing, next spacing (R2 R4 R5)
    run = 1'b1;
    for (int v = 0; v < NV; v++) begin
      period_sel = VSEL[v];
      clear_count();
      wait_low(VFIRST[v] + 10, g);
      check($sformatf("R2 first spacing code %0d", VSEL[v]), g, VFIRST[v]);
      tick(1);
      check("R4 pulse width one cycle", int'(pulse_n), 1);
      wait_low(VNEXT[v] + 10, g);
      check($sformatf("R5 repeat spacing code %0d", VSEL[v]), g, VNEXT[v] - 1);
      check("R9 flag after event", int'(interval_flag), 1);
    end

    // R3: uneven tenth split
    period_sel = 3'd0;
    clear_count();
    sum = 0;
    for (int s = 0; s < 5; s++) begin
      wait_low(20, g);
      check($sformatf("R3 tenth slot %0d", s), g, SPLIT[s]);
      sum += g;
    end
    check("R3 five slots sum", sum, H);
    wait_low(20, g);
    check("R3 pattern restarts", g, SPLIT[0]);

    // R7: stop keeps elapsed time
    period_sel = 3'd1;
    clear_count();
    tick(20);
    run = 1'b0;
    count_lows(30, lows);
    check("R7 no pulse while stopped", lows, 0);
    check("R7 flag clear while stopped", int'(interval_flag), 0);
    run = 1'b1;
    wait_low(100, g);
    check("R7 t1+t2 remainder", g, 2*H - 20);

    // R8: clear mid interval restarts count
    clear_count();
    tick(30);
    clear_count();
    check("R8 flag cleared", int'(interval_flag), 0);
    wait_low(100, g);
    check("R8 full period after clear", g, 2*H);
    tick(10);
    check("R9 flag sticky", int'(interval_flag), 1);

    // R6: single shot
    period_sel = 3'd0;
    one_shot = 1'b1;
    clear_count();
    wait_low(20, g);
    check("R6 single shot first", g, 5);
    count_lows(60, lows);
    check("R6 halted after shot", lows, 0);
    check("R6 flag kept", int'(interval_flag), 1);
    cnt_reset = 1'b1;
    tick(1);
    check("R8 clear drops flag", int'(interval_flag), 0);
    cnt_reset = 1'b0;
    wait_low(20, g);
    check("R6 rearmed by clear", g, 5);
    one_shot = 1'b0;

    // R10: output disabled
    out_en = 1'b0;
    clear_count();
    count_lows(12, lows);
    check("R10 pin high when disabled", lows, 0);
    check("R10 flag still set", int'(interval_flag), 1);
    out_en = 1'b1;

    // R11: busy routing
    period_sel = 3'd7;
    clear_count();
    busy_in = 1'b1;
    tick(1);
    check("R11 busy drives low", int'(pulse_n), 0);
    busy_in = 1'b0;
    tick(1);
    check("R11 busy released high", int'(pulse_n), 1);
    busy_in = 1'b1;
    out_en = 1'b0;
    tick(1);
    check("R11 busy masked by disable", int'(pulse_n), 1);
    busy_in = 1'b0;
    out_en = 1'b1;
    count_lows(40, lows);
    check("R11 no interval pulses", lows, 0);
    check("R11 no flag", int'(interval_flag), 0);

    // R12: reserved codes
    for (int c = 5; c <= 6; c++) begin
      period_sel = 3'(c);
      clear_count();
      count_lows(100, lows);
      check($sformatf("R12 code %0d no pulse", c), lows, 0);
      check($sformatf("R12 code %0d no flag", c), int'(interval_flag), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule